// File: doc/BRIEF.md
# Two-Lane Triangle Cull Unit

This block sits between a geometry stage and a rasteriser. Each clock it can take up to two screen-space triangles, one on each input lane. Every triangle has three vertices, given as signed fixed-point X and Y coordinates, and an opaque tag. The block throws away triangles that cannot produce a pixel. These are triangles wholly outside the viewport, triangles that face away from the viewer, and triangles that enclose no pixel-centre sample. Triangles that survive go into a small in-order queue. The queue drains one triangle per clock to the downstream stage.

The output lane is half as wide as the input, so the block runs at full input rate only while about half of the incoming geometry is culled. When both lanes keep producing survivors, the queue fills and the shared input ready drops until at least two slots are free again. Five counters report traffic: accepted triangles, culls for each reason, and emitted triangles.

The queue control is a three-state machine driven by the queue's next fill level:
- **Q_EMPTY**: nothing is stored, so out_valid is low and in_ready is high.
- **Q_FLOW**: at least one entry is stored and at least two slots are free, so both out_valid and in_ready are high.
- **Q_HOLD**: fewer than two slots are free, so in_ready is low and out_valid is high.

Each cycle the next state is chosen from the next fill level:
- a next fill of zero goes to Q_EMPTY;
- a next fill above DEPTH-2 goes to Q_HOLD;
- any other next fill goes to Q_FLOW.

Any state can move to any other in one cycle. For example, Q_EMPTY goes straight to Q_HOLD when DEPTH is 2 and a pair survives.

Top module: `tri_cull_pair`

## Requirements
- R1: When in_ready is high, every lane with its in_valid bit set is accepted in that clock, and cnt_accepted rises by the number of accepted lanes. Vertex k sits in bits [k*CW +: CW] of the lane's vx and vy buses. Coordinates are two's complement with FB fractional bits.
- R2: out_valid and the output fields describe at most one triangle per clock. That triangle leaves when out_valid and out_ready are both high, which raises cnt_emitted by one. A survivor accepted at a clock edge is visible on the outputs right after that edge if the queue was empty.
- R3: A triangle is culled as off-screen, and counted in cnt_off, when its largest X < 0, its smallest X >= VP_W*2^FB, its largest Y < 0, or its smallest Y >= VP_H*2^FB.
- R4: The doubled area is A = (x1-x0)(y2-y0) - (x2-x0)(y1-y0). With front_ccw=1 a triangle with A < 0 is back-facing. With front_ccw=0 a triangle with A > 0 is back-facing. Back-facing triangles are culled and counted in cnt_back.
- R5: A triangle is culled as empty, and counted in cnt_empty, in either of two cases. The first case is A = 0. The second case is that no sample position n*2^FB + 2^(FB-1) (n any integer) lies within its X range, or none lies within its Y range, ranges inclusive.
- R6: Each triangle is counted under exactly one reason. Off-screen takes priority over empty, and empty takes priority over back-facing.
- R7: The queue holds DEPTH entries. in_ready is high exactly when at least two entries are free, so no survivor is ever dropped or overwritten.
- R8: Survivors leave in acceptance order: lane 0 before lane 1 within a clock, and earlier clocks before later ones.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_vx, out_vy and out_tag hold their values.
- R10: After reset, out_valid is low, in_ready is high and all five counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| front_ccw | input | 1 | Winding that counts as front-facing (1: positive doubled area) |
| in_valid | input | 2 | Per-lane triangle present, bit 0 for lane 0 |
| in_ready | output | 1 | Shared ready for both lanes |
| l0_vx | input | 3*CW | Lane 0 vertex X coordinates |
| l0_vy | input | 3*CW | Lane 0 vertex Y coordinates |
| l0_tag | input | TW | Lane 0 tag |
| l1_vx | input | 3*CW | Lane 1 vertex X coordinates |
| l1_vy | input | 3*CW | Lane 1 vertex Y coordinates |
| l1_tag | input | TW | Lane 1 tag |
| out_valid | output | 1 | Surviving triangle present |
| out_ready | input | 1 | Downstream takes the triangle |
| out_vx | output | 3*CW | Output vertex X coordinates |
| out_vy | output | 3*CW | Output vertex Y coordinates |
| out_tag | output | TW | Output tag |
| cnt_accepted | output | CNT_W | Triangles accepted |
| cnt_off | output | CNT_W | Triangles culled as off-screen |
| cnt_empty | output | CNT_W | Triangles culled as covering no sample |
| cnt_back | output | CNT_W | Triangles culled as back-facing |
| cnt_emitted | output | CNT_W | Triangles emitted |

## Verification
The assertions check four properties on every cycle:
- the queue never overflows or underflows;
- in_ready is only high when two slots are free;
- a stalled output holds steady;
- the accepted and emitted counters never step by more than two and one.

The cull decisions can only be shown by the bench's scenarios:
- the geometric verdicts and their priority order;
- the effect of the winding input;
- the exact survivor order under backpressure.

The bench checks these against hand-derived expectations for each triangle.

// File: rtl/tri_cull_pkg.sv
package tri_cull_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_FLOW,
        Q_HOLD
    } q_state_e;

    typedef enum logic [1:0] {
        VERDICT_KEEP,
        VERDICT_OFF,
        VERDICT_EMPTY,
        VERDICT_BACK
    } verdict_e;

endpackage

// File: rtl/tri_cull_eval.sv
module tri_cull_eval
    import tri_cull_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FB   = 4,
    parameter int VP_W = 64,
    parameter int VP_H = 48
) (
    input  logic [3*CW-1:0] vx,
    input  logic [3*CW-1:0] vy,
    input  logic            front_ccw,
    output verdict_e        verdict
);
    localparam int EW = CW + 3;
    localparam int AW = 2 * EW;
    localparam logic signed [EW-1:0] X_LIM = EW'(VP_W * (1 << FB));
    localparam logic signed [EW-1:0] Y_LIM = EW'(VP_H * (1 << FB));
    localparam logic signed [EW-1:0] HALF  = EW'(1 << (FB - 1));
    localparam logic signed [EW-1:0] RND   = EW'((1 << FB) - 1);

    logic signed [EW-1:0] px [3];
    logic signed [EW-1:0] py [3];

    for (genvar k = 0; k < 3; k++) begin : g_vtx
        assign px[k] = EW'($signed(vx[k*CW +: CW]));
        assign py[k] = EW'($signed(vy[k*CW +: CW]));
    end

    function automatic logic signed [EW-1:0] lo3(input logic signed [EW-1:0] a,
                                                 input logic signed [EW-1:0] b,
                                                 input logic signed [EW-1:0] c);
        logic signed [EW-1:0] m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

    function automatic logic signed [EW-1:0] hi3(input logic signed [EW-1:0] a,
                                                 input logic signed [EW-1:0] b,
                                                 input logic signed [EW-1:0] c);
        logic signed [EW-1:0] m;
        m = (a > b) ? a : b;
        return (c > m) ? c : m;
    endfunction

    logic signed [EW-1:0] x_lo, x_hi, y_lo, y_hi;
    logic signed [AW-1:0] area2;
    logic                 off_scr, no_col, no_row, flat, faces_back;

    always_comb begin
        x_lo  = lo3(px[0], px[1], px[2]);
        x_hi  = hi3(px[0], px[1], px[2]);
        y_lo  = lo3(py[0], py[1], py[2]);
        y_hi  = hi3(py[0], py[1], py[2]);
        area2 = (AW'(px[1]) - AW'(px[0])) * (AW'(py[2]) - AW'(py[0]))
              - (AW'(px[2]) - AW'(px[0])) * (AW'(py[1]) - AW'(py[0]));
        off_scr = (x_hi < 0) || (x_lo >= X_LIM) || (y_hi < 0) || (y_lo >= Y_LIM);
        // a sample column exists iff ceil((lo-half)/S) <= floor((hi-half)/S)
        no_col = ((x_lo - HALF + RND) >>> FB) > ((x_hi - HALF) >>> FB);
        no_row = ((y_lo - HALF + RND) >>> FB) > ((y_hi - HALF) >>> FB);
        flat   = (area2 == '0);
        faces_back = front_ccw ? (area2 < 0) : (area2 > 0);

        // R6 priority: off-screen, then empty, then back-facing
        if (off_scr) begin
            verdict = VERDICT_OFF;
        end else if (flat || no_col || no_row) begin
            verdict = VERDICT_EMPTY;
        end else if (faces_back) begin
            verdict = VERDICT_BACK;
        end else begin
            verdict = VERDICT_KEEP;
        end
    end

endmodule

// File: rtl/tri_cull_queue.sv
module tri_cull_queue
    import tri_cull_pkg::*;
#(
    parameter  int DEPTH = 4,
    parameter  int DW    = 8,
    localparam int FW    = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_a,
    input  logic          push_b,
    input  logic [DW-1:0] din_a,
    input  logic [DW-1:0] din_b,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [FW-1:0] fill,
    output logic          room2,
    output logic          not_empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [FW-1:0] fill_q, fill_d;
    q_state_e      state_q, state_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input int k);
        int t;
        t = int'(p) + k;
        if (t >= DEPTH) t = t - DEPTH;
        return PW'(t);
    endfunction

    // next fill level decides the next state
    always_comb begin
        fill_d = fill_q + FW'(push_a) + FW'(push_b) - FW'(pop);
        if (fill_d == '0) begin
            state_d = Q_EMPTY;
        end else if (fill_d > FW'(DEPTH - 2)) begin
            state_d = Q_HOLD;
        end else begin
            state_d = Q_FLOW;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            fill_q  <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            wr_ptr  <= bump(wr_ptr, int'(push_a) + int'(push_b));
            rd_ptr  <= bump(rd_ptr, int'(pop));
        end
    end

    // storage: lane a first, lane b behind it (R8)
    always_ff @(posedge clk) begin
        if (push_a) mem[wr_ptr] <= din_a;
        if (push_b) mem[push_a ? bump(wr_ptr, 1) : wr_ptr] <= din_b;
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            Q_EMPTY: begin room2 = 1'b1; not_empty = 1'b0; end
            Q_FLOW:  begin room2 = 1'b1; not_empty = 1'b1; end
            Q_HOLD:  begin room2 = 1'b0; not_empty = 1'b1; end
            default: begin room2 = 1'b0; not_empty = 1'b0; end
        endcase
    end

    assign dout = mem[rd_ptr];
    assign fill = fill_q;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FW'(DEPTH));

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> fill_q != '0);

endmodule

// File: rtl/tri_cull_pair.sv
module tri_cull_pair
    import tri_cull_pkg::*;
#(
    parameter int CW    = 16,
    parameter int FB    = 4,
    parameter int TW    = 8,
    parameter int VP_W  = 64,
    parameter int VP_H  = 48,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             front_ccw,
    input  logic [1:0]       in_valid,
    output logic             in_ready,
    input  logic [3*CW-1:0]  l0_vx,
    input  logic [3*CW-1:0]  l0_vy,
    input  logic [TW-1:0]    l0_tag,
    input  logic [3*CW-1:0]  l1_vx,
    input  logic [3*CW-1:0]  l1_vy,
    input  logic [TW-1:0]    l1_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3*CW-1:0]  out_vx,
    output logic [3*CW-1:0]  out_vy,
    output logic [TW-1:0]    out_tag,
    output logic [CNT_W-1:0] cnt_accepted,
    output logic [CNT_W-1:0] cnt_off,
    output logic [CNT_W-1:0] cnt_empty,
    output logic [CNT_W-1:0] cnt_back,
    output logic [CNT_W-1:0] cnt_emitted
);
    localparam int DW = 6 * CW + TW;
    localparam int FW = $clog2(DEPTH + 1);

    logic [3*CW-1:0] lane_vx  [2];
    logic [3*CW-1:0] lane_vy  [2];
    logic [TW-1:0]   lane_tag [2];
    logic [DW-1:0]   lane_ent [2];
    verdict_e        lane_v   [2];
    logic [1:0]      took, kept;
    logic [DW-1:0]   q_head;
    logic [FW-1:0]   q_fill;
    logic            q_room2, q_nonempty, pop;
    logic [1:0]      n_off, n_empty, n_back;

    assign lane_vx[0]  = l0_vx;
    assign lane_vy[0]  = l0_vy;
    assign lane_tag[0] = l0_tag;
    assign lane_vx[1]  = l1_vx;
    assign lane_vy[1]  = l1_vy;
    assign lane_tag[1] = l1_tag;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        tri_cull_eval #(
            .CW(CW), .FB(FB), .VP_W(VP_W), .VP_H(VP_H)
        ) eval_i (
            .vx        (lane_vx[l]),
            .vy        (lane_vy[l]),
            .front_ccw (front_ccw),
            .verdict   (lane_v[l])
        );
        assign took[l]     = in_valid[l] && in_ready;
        assign kept[l]     = took[l] && (lane_v[l] == VERDICT_KEEP);
        assign lane_ent[l] = {lane_vx[l], lane_vy[l], lane_tag[l]};
    end

    tri_cull_queue #(.DEPTH(DEPTH), .DW(DW)) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_a    (kept[0]),
        .push_b    (kept[1]),
        .din_a     (lane_ent[0]),
        .din_b     (lane_ent[1]),
        .pop       (pop),
        .dout      (q_head),
        .fill      (q_fill),
        .room2     (q_room2),
        .not_empty (q_nonempty)
    );

    assign in_ready  = q_room2;
    assign out_valid = q_nonempty;
    assign pop       = q_nonempty && out_ready;
    assign {out_vx, out_vy, out_tag} = q_head;

    always_comb begin
        n_off   = 2'(took[0] && lane_v[0] == VERDICT_OFF)
                + 2'(took[1] && lane_v[1] == VERDICT_OFF);
        n_empty = 2'(took[0] && lane_v[0] == VERDICT_EMPTY)
                + 2'(took[1] && lane_v[1] == VERDICT_EMPTY);
        n_back  = 2'(took[0] && lane_v[0] == VERDICT_BACK)
                + 2'(took[1] && lane_v[1] == VERDICT_BACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_accepted <= '0;
            cnt_off      <= '0;
            cnt_empty    <= '0;
            cnt_back     <= '0;
            cnt_emitted  <= '0;
        end else begin
            cnt_accepted <= cnt_accepted + CNT_W'(took[0]) + CNT_W'(took[1]);
            cnt_off      <= cnt_off   + CNT_W'(n_off);
            cnt_empty    <= cnt_empty + CNT_W'(n_empty);
            cnt_back     <= cnt_back  + CNT_W'(n_back);
            cnt_emitted  <= cnt_emitted + CNT_W'(pop);
        end
    end

    a_r7_ready_space: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> q_fill <= FW'(DEPTH - 2));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)
                                       && $stable(out_vx) && $stable(out_vy)));

    a_r2_emit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (CNT_W'(cnt_emitted - $past(cnt_emitted)) <= CNT_W'(1)));

    a_r1_accept_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (CNT_W'(cnt_accepted - $past(cnt_accepted)) <= CNT_W'(2)));

endmodule

// File: tb/tri_cull_pair_tb.sv
module tri_cull_pair_tb_top;
    localparam int CW = 16;
    localparam int TW = 8;
    localparam int CNT_W = 16;
    localparam int NV = 13;
    // x0,y0,x1,y1,x2,y2 in 1/16 pixel, expected verdict: 0 keep 1 off 2 empty 3 back
    localparam int TV [NV][7] = '{
        '{   0,    0,  160,    0,    0,  160, 0},
        '{   0,    0,    0,  160,  160,    0, 3},
        '{1040,    0, 1200,    0, 1040,  160, 1},
        '{   0, -200,  160, -200,    0,  -40, 1},
        '{   0,    0,   80,   80,  160,  160, 2},
        '{  20,    0,   22,    0,   20,  160, 2},
        '{   0,   41,  160,   41,    0,   43, 2},
        '{   7,    7,    9,    7,    7,    9, 0},
        '{-100, -100,  200, -100, -100,  200, 0},
        '{1100,    0, 1100,  160, 1260,    0, 1},
        '{  20,    0,   20,  160,   22,    0, 2},
        '{1024,    0, 1100,    0, 1024,  100, 1},
        '{-160,    0,    0,    0, -160,  160, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic front_ccw = 1'b1;
    logic [1:0] in_valid = 2'b00;
    logic in_ready;
    logic [3*CW-1:0] l0_vx = '0, l0_vy = '0, l1_vx = '0, l1_vy = '0;
    logic [TW-1:0] l0_tag = '0, l1_tag = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [3*CW-1:0] out_vx, out_vy;
    logic [TW-1:0] out_tag;
    logic [CNT_W-1:0] cnt_accepted, cnt_off, cnt_empty, cnt_back, cnt_emitted;

    int n_chk = 0;
    int n_bad = 0;
    int rx_n = 0;
    int rx_tag [32];
    logic [3*CW-1:0] rx_vx [32];

    always #10 clk = ~clk;

    tri_cull_pair dut_i (
        .clk(clk), .rst_n(rst_n), .front_ccw(front_ccw),
        .in_valid(in_valid), .in_ready(in_ready),
        .l0_vx(l0_vx), .l0_vy(l0_vy), .l0_tag(l0_tag),
        .l1_vx(l1_vx), .l1_vy(l1_vy), .l1_tag(l1_tag),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_vx(out_vx), .out_vy(out_vy), .out_tag(out_tag),
        .cnt_accepted(cnt_accepted), .cnt_off(cnt_off), .cnt_empty(cnt_empty),
        .cnt_back(cnt_back), .cnt_emitted(cnt_emitted)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && rx_n < 32) begin
            rx_tag[rx_n] = int'(out_tag);
            rx_vx[rx_n]  = out_vx;
            rx_n++;
        end
    end

    function automatic logic [3*CW-1:0] pk(input int a, input int b, input int c);
        return {CW'(c), CW'(b), CW'(a)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        in_valid = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rx_n = 0;
    endtask

    // called at posedge+1; leaves at posedge+1 after the accepting edge
    task automatic send(input int i0, input bit v0, input int i1, input bit v1);
        while (!in_ready) begin @(posedge clk); #1; end
        if (v0) begin
            l0_vx = pk(TV[i0][0], TV[i0][2], TV[i0][4]);
            l0_vy = pk(TV[i0][1], TV[i0][3], TV[i0][5]);
            l0_tag = TW'(16 + i0);
        end
        if (v1) begin
            l1_vx = pk(TV[i1][0], TV[i1][2], TV[i1][4]);
            l1_vy = pk(TV[i1][1], TV[i1][3], TV[i1][5]);
            l1_tag = TW'(16 + i1);
        end
        in_valid = {v1, v0};
        @(posedge clk); #1;
        in_valid = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int exp_tags [16];
        int n_exp;
        int e_off, e_empty, e_back;

        // R10 reset state
        do_reset();
        check(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
        check(cnt_accepted == 0 && cnt_emitted == 0, "R10 counters", int'(cnt_accepted), 0);
        check(cnt_off == 0 && cnt_empty == 0 && cnt_back == 0, "R10 cull counters",
              int'(cnt_off), 0);

        // table walk, pairs back to back, downstream always ready
        n_exp = 0; e_off = 0; e_empty = 0; e_back = 0;
        for (int i = 0; i < NV; i++) begin
            if (TV[i][6] == 0) begin exp_tags[n_exp] = 16 + i; n_exp++; end
            if (TV[i][6] == 1) e_off++;
            if (TV[i][6] == 2) e_empty++;
            if (TV[i][6] == 3) e_back++;
        end
        for (int i = 0; i < NV; i += 2) send(i, 1'b1, i + 1, (i + 1) < NV);
        repeat (8) @(posedge clk);
        #1;
        check(rx_n == n_exp, "R2 survivor count", rx_n, n_exp);
        for (int k = 0; k < n_exp; k++) begin
            int t;
            t = exp_tags[k] - 16;
            check(rx_tag[k] == exp_tags[k], "R8 survivor order", rx_tag[k], exp_tags[k]);
            check(rx_vx[k] == pk(TV[t][0], TV[t][2], TV[t][4]), "R1 vertex packing",
                  int'(rx_vx[k][CW-1:0]), TV[t][0]);
        end
        check(int'(cnt_accepted) == NV, "R1 accepted count", int'(cnt_accepted), NV);
        check(int'(cnt_off) == e_off, "R3 off-screen count", int'(cnt_off), e_off);
        check(int'(cnt_empty) == e_empty, "R5 empty count (R6 priority)", int'(cnt_empty), e_empty);
        check(int'(cnt_back) == e_back, "R4 back count (R6 priority)", int'(cnt_back), e_back);
        check(int'(cnt_emitted) == n_exp, "R2 emitted count", int'(cnt_emitted), n_exp);

        // backpressure: all four survive, queue must fill and hold
        do_reset();
        out_ready = 1'b0;
        send(0, 1'b1, 7, 1'b1);
        check(in_ready == 1'b1, "R7 ready with two free", int'(in_ready), 1);
        check(out_valid == 1'b1 && int'(out_tag) == 16, "R2 head visible", int'(out_tag), 16);
        send(8, 1'b1, 12, 1'b1);
        check(in_ready == 1'b0, "R7 ready low when full", int'(in_ready), 0);
        repeat (2) @(posedge clk);
        #1;
        check(out_valid == 1'b1 && int'(out_tag) == 16, "R9 stalled head stable",
              int'(out_tag), 16);
        check(in_ready == 1'b0, "R7 ready held low", int'(in_ready), 0);
        out_ready = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check(rx_n == 4, "R7 nothing dropped", rx_n, 4);
        check(rx_tag[0] == 16 && rx_tag[1] == 23, "R8 lane order", rx_tag[1], 23);
        check(rx_tag[2] == 24 && rx_tag[3] == 28, "R8 cycle order", rx_tag[3], 28);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R7 drained", int'(in_ready), 1);

        // winding flip: former front becomes back and vice versa; lane 1 alone
        do_reset();
        front_ccw = 1'b0;
        send(0, 1'b1, 1, 1'b1);
        send(0, 1'b0, 1, 1'b1);
        repeat (4) @(posedge clk);
        #1;
        check(rx_n == 2, "R4 cw survivors", rx_n, 2);
        check(rx_tag[0] == 17 && rx_tag[1] == 17, "R4 cw front kept", rx_tag[0], 17);
        check(int'(cnt_back) == 1, "R4 cw back count", int'(cnt_back), 1);
        check(int'(cnt_accepted) == 3, "R1 single lane accept", int'(cnt_accepted), 3);
        front_ccw = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule